// File: doc/BRIEF.md
# Interrupt Destination Matcher with Arbitration

This block decides which of `N_AGENTS` local agents should receive an inter-processor interrupt. A requesting agent presents a small control word and an 8-bit destination. The control word carries the shorthand, the addressing mode and the delivery mode. Every agent supplies its 8-bit physical ID, its 8-bit logical ID, a 4-bit logical format code and an enable. Each agent is tested against the request in parallel. The result is a per-agent deliver mask, which is registered and presented for exactly one cycle together with a done pulse.

In lowest-priority delivery the mask is cut down to a single agent. A rotating pointer remembers the last agent chosen. The next search begins just past that agent, wraps at `N_AGENTS`, and takes the first agent that both matches and is enabled. The pointer moves only when such an agent is found. Every other delivery mode sends to all matching agents, whatever their enables.

Top module: `ipi_dest_matcher`

## Requirements
- R1: Control bits [5:4] hold the shorthand. 0 uses the destination rules of R2 to R5. 1 selects only the agent whose index equals `req_src`. 2 selects every agent. 3 selects every agent except `req_src`.
- R2: With shorthand 0 and control bit [3] = 0 (physical addressing), an agent matches when `req_dest` equals its physical ID, or when `req_dest` is 8'hFF.
- R3: With shorthand 0 and control bit [3] = 1 (logical addressing), an agent whose format code is 4'hF (flat) matches when its logical ID AND `req_dest` is nonzero.
- R4: In logical addressing, an agent whose format code is 4'h0 (cluster) matches when the upper nibbles of its logical ID and `req_dest` are equal and the AND of the lower nibbles is nonzero.
- R5: In logical addressing, an agent with any other format code never matches.
- R6: Control bits [2:0] give the delivery mode, and 3'b001 is lowest priority. In that mode at most one agent is delivered. It is the first agent that matches and is enabled, searching upward from the agent after the previously chosen one and wrapping at `N_AGENTS`. The first search after reset starts at agent 0.
- R7: In lowest-priority mode, if no matching agent is enabled, the mask is zero and the pointer keeps its value. Requests in other modes never move the pointer.
- R8: For any delivery mode other than 3'b001, every matching agent is delivered, including agents whose enable is low.
- R9: The mask and `deliver_done` appear in the cycle after a `req_valid` cycle and last exactly one cycle. Otherwise both are zero, including right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per command |
| req_ctrl | input | 6 | Shorthand [5:4], logical addressing [3], delivery mode [2:0] |
| req_dest | input | 8 | Destination field |
| req_src | input | IDX_W | Index of the requesting agent |
| agent_phys_id | input | N_AGENTS*8 | Physical IDs, agent i in bits [8i+7:8i] |
| agent_log_id | input | N_AGENTS*8 | Logical IDs, agent i in bits [8i+7:8i] |
| agent_fmt | input | N_AGENTS*4 | Logical format codes, agent i in bits [4i+3:4i] |
| agent_en | input | N_AGENTS | Per-agent enable, used only for lowest-priority choice |
| deliver_mask | output | N_AGENTS | One bit per agent receiving the interrupt |
| deliver_done | output | 1 | One-cycle pulse marking a resolved request |

## Verification
The assertions check the following on every cycle. The done pulse follows each strobe. The mask stays quiet outside that pulse. A lowest-priority result never names more than one agent, and that agent is a valid candidate. The pointer moves only on a successful grant, and then to the granted index. What only the bench scenarios can show is the matching arithmetic for each address form and format code, the exclusion of the requester under shorthand 3, the rotation order across several grants with a disabled agent skipped, and the fact that a failed search leaves the rotation where it was.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int CTRL_W = 6;

  typedef enum logic [1:0] {
    SH_DEST     = 2'd0,
    SH_SELF     = 2'd1,
    SH_ALL      = 2'd2,
    SH_OTHERS   = 2'd3
  } shorthand_e;

  localparam logic [2:0] DM_LOWEST   = 3'b001;
  localparam logic [3:0] FMT_FLAT    = 4'hF;
  localparam logic [3:0] FMT_CLUSTER = 4'h0;

  function automatic logic phys_hit(input logic [7:0] id, input logic [7:0] dest);
    return (dest == 8'hFF) || (dest == id);
  endfunction

  function automatic logic logical_hit(input logic [7:0] lid, input logic [3:0] fmt,
                                       input logic [7:0] dest);
    logic r;
    case (fmt)
      FMT_FLAT:    r = |(lid & dest);
      FMT_CLUSTER: r = (lid[7:4] == dest[7:4]) && (|(lid[3:0] & dest[3:0]));
      default:     r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ipi_agent_match.sv
module ipi_agent_match
  import ipi_pkg::*;
#(
  parameter int IDX_W    = 2,
  parameter int SELF_IDX = 0
) (
  input  logic [1:0]       shorthand,
  input  logic             logical_mode,
  input  logic [7:0]       dest,
  input  logic [IDX_W-1:0] src,
  input  logic [7:0]       phys_id,
  input  logic [7:0]       log_id,
  input  logic [3:0]       fmt,
  output logic             hit
);

  localparam logic [IDX_W-1:0] ME = IDX_W'(SELF_IDX);

  logic dest_hit;
  logic is_self;

  assign is_self  = (src == ME);
  assign dest_hit = logical_mode ? logical_hit(log_id, fmt, dest) : phys_hit(phys_id, dest);

  always_comb begin
    case (shorthand_e'(shorthand))
      SH_DEST:   hit = dest_hit;
      SH_SELF:   hit = is_self;
      SH_ALL:    hit = 1'b1;
      SH_OTHERS: hit = !is_self;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int N_AGENTS = 4,
  parameter int IDX_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_AGENTS-1:0] cand,
  input  logic                commit,
  output logic                grant_valid,
  output logic [N_AGENTS-1:0] grant_mask
);

  localparam logic [IDX_W-1:0] LAST_INIT = IDX_W'(N_AGENTS - 1);

  logic [IDX_W-1:0] last_q;
  logic [IDX_W-1:0] grant_idx;
  logic             advance;

  function automatic logic [IDX_W-1:0] step_from(input logic [IDX_W-1:0] base, input int k);
    int s;
    s = int'(base) + k;
    if (s >= N_AGENTS) s = s - N_AGENTS;
    return IDX_W'(s);
  endfunction

  always_comb begin
    grant_valid = 1'b0;
    grant_idx   = last_q;
    for (int k = 1; k <= N_AGENTS; k++) begin
      if (!grant_valid && cand[step_from(last_q, k)]) begin
        grant_valid = 1'b1;
        grant_idx   = step_from(last_q, k);
      end
    end
  end

  assign grant_mask = grant_valid ? (N_AGENTS'(1) << grant_idx) : '0;
  assign advance    = commit && grant_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= LAST_INIT;
    else if (advance) last_q <= grant_idx;
  end

  a_r7_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(last_q));
  a_r6_ptr_to_grant: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> last_q == $past(grant_idx));
  a_r6_grant_is_cand: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (grant_mask & cand) == grant_mask);
  a_r7_no_cand_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |-> !grant_valid);

endmodule

// File: rtl/ipi_dest_matcher.sv
module ipi_dest_matcher
  import ipi_pkg::*;
#(
  parameter int N_AGENTS = 4,
  parameter int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [CTRL_W-1:0]     req_ctrl,
  input  logic [7:0]            req_dest,
  input  logic [IDX_W-1:0]      req_src,
  input  logic [N_AGENTS*8-1:0] agent_phys_id,
  input  logic [N_AGENTS*8-1:0] agent_log_id,
  input  logic [N_AGENTS*4-1:0] agent_fmt,
  input  logic [N_AGENTS-1:0]   agent_en,
  output logic [N_AGENTS-1:0]   deliver_mask,
  output logic                  deliver_done
);

  logic [1:0]          shorthand;
  logic                logical_mode;
  logic                lowest;
  logic [N_AGENTS-1:0] hit_vec;
  logic [N_AGENTS-1:0] cand_vec;
  logic [N_AGENTS-1:0] grant_mask;
  logic                grant_valid;
  logic [N_AGENTS-1:0] mask_next;
  logic                lowest_q;

  assign shorthand    = req_ctrl[5:4];
  assign logical_mode = req_ctrl[3];
  assign lowest       = (req_ctrl[2:0] == DM_LOWEST);

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    ipi_agent_match #(.IDX_W(IDX_W), .SELF_IDX(g)) u_match (
      .shorthand    (shorthand),
      .logical_mode (logical_mode),
      .dest         (req_dest),
      .src          (req_src),
      .phys_id      (agent_phys_id[g*8 +: 8]),
      .log_id       (agent_log_id[g*8 +: 8]),
      .fmt          (agent_fmt[g*4 +: 4]),
      .hit          (hit_vec[g])
    );
  end

  assign cand_vec = hit_vec & agent_en;

  ipi_rr_pick #(.N_AGENTS(N_AGENTS), .IDX_W(IDX_W)) u_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .cand        (cand_vec),
    .commit      (req_valid && lowest),
    .grant_valid (grant_valid),
    .grant_mask  (grant_mask)
  );

  assign mask_next = lowest ? grant_mask : hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deliver_mask <= '0;
      deliver_done <= 1'b0;
      lowest_q     <= 1'b0;
    end else begin
      deliver_mask <= req_valid ? mask_next : '0;
      deliver_done <= req_valid;
      lowest_q     <= req_valid && lowest;
    end
  end

  a_r9_done_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> deliver_done);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !deliver_done);
  a_r9_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !deliver_done |-> deliver_mask == '0);
  a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (deliver_done && lowest_q) |-> $onehot0(deliver_mask));
  a_r1_all_shorthand: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !lowest && shorthand == 2'd2) |=> deliver_mask == '1);
  a_r8_grant_within_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lowest) |=> (deliver_mask & ~$past(agent_en)) == '0);

endmodule

// File: tb/tb_ipi_dest_matcher.sv
`timescale 1ns/1ps
module tb_ipi_dest_matcher;

  localparam int N  = 4;
  localparam int IW = 2;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [5:0]    req_ctrl = '0;
  logic [7:0]    req_dest = '0;
  logic [IW-1:0] req_src = '0;
  logic [N*8-1:0] agent_phys_id;
  logic [N*8-1:0] agent_log_id;
  logic [N*4-1:0] agent_fmt;
  logic [N-1:0]   agent_en;
  logic [N-1:0]   deliver_mask;
  logic           deliver_done;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ipi_dest_matcher #(.N_AGENTS(N)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ctrl(req_ctrl),
    .req_dest(req_dest), .req_src(req_src), .agent_phys_id(agent_phys_id),
    .agent_log_id(agent_log_id), .agent_fmt(agent_fmt), .agent_en(agent_en),
    .deliver_mask(deliver_mask), .deliver_done(deliver_done)
  );

  // {ctrl[5:0], dest[7:0], src[1:0], expected mask[3:0]}
  localparam logic [19:0] VEC [NV] = '{
    {6'b00_0_000, 8'h12, 2'd0, 4'b0100},  // R2 id match, R8 disabled agent 2 still delivered
    {6'b00_0_000, 8'hFF, 2'd0, 4'b1111},  // R2 broadcast
    {6'b00_0_000, 8'h20, 2'd0, 4'b0000},  // R2 no id
    {6'b00_1_000, 8'h03, 2'd0, 4'b0011},  // R3 flat
    {6'b00_1_000, 8'h16, 2'd0, 4'b1110},  // R4 cluster 1 plus flat agent 1
    {6'b00_1_000, 8'h24, 2'd0, 4'b0000},  // R4 cluster nibble mismatch
    {6'b01_0_000, 8'h00, 2'd2, 4'b0100},  // R1 self
    {6'b10_0_000, 8'h00, 2'd1, 4'b1111},  // R1 all
    {6'b11_0_000, 8'h00, 2'd1, 4'b1101},  // R1 all but self
    {6'b00_0_100, 8'h13, 2'd0, 4'b1000}   // R8 other mode
  };

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] c, input logic [7:0] d, input logic [IW-1:0] s);
    @(negedge clk);
    req_valid = 1'b1; req_ctrl = c; req_dest = d; req_src = s;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run(input string tag, input logic [5:0] c, input logic [7:0] d,
                     input logic [IW-1:0] s, input logic [N-1:0] exp);
    issue(c, d, s);
    chk(tag, deliver_mask, exp);
    chk({tag, " done"}, {3'b000, deliver_done}, 4'b0001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      agent_phys_id[i*8 +: 8] = 8'h10 + 8'(i);
    end
    agent_log_id = {8'h14, 8'h12, 8'h02, 8'h01};
    agent_fmt    = {4'h0, 4'h0, 4'hF, 4'hF};
    agent_en     = 4'b1011;
    repeat (3) @(negedge clk);
    chk("R9 reset mask", deliver_mask, 4'b0000);
    chk("R9 reset done", {3'b000, deliver_done}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run($sformatf("vector %0d", i), VEC[i][19:14], VEC[i][13:6], VEC[i][5:4], VEC[i][3:0]);
    end

    // R9 pulse lasts one cycle
    @(negedge clk);
    chk("R9 mask after pulse", deliver_mask, 4'b0000);
    chk("R9 done after pulse", {3'b000, deliver_done}, 4'b0000);

    // R6 rotation, agent 2 disabled
    run("R6 first from 0", 6'b10_0_001, 8'h00, 2'd0, 4'b0001);
    run("R6 next 1",       6'b10_0_001, 8'h00, 2'd0, 4'b0010);
    run("R6 skip disabled",6'b10_0_001, 8'h00, 2'd0, 4'b1000);
    run("R6 wrap",         6'b10_0_001, 8'h00, 2'd0, 4'b0001);
    // R7 only disabled agent matches
    run("R7 none enabled", 6'b00_0_001, 8'h12, 2'd0, 4'b0000);
    run("R7 ptr kept",     6'b10_0_001, 8'h00, 2'd0, 4'b0010);
    run("R8 fixed all",    6'b10_0_000, 8'h00, 2'd0, 4'b1111);
    run("R7 fixed no move",6'b10_0_001, 8'h00, 2'd0, 4'b1000);
    // R6 candidate filter by match
    run("R6 logical lowest", 6'b00_1_001, 8'h03, 2'd0, 4'b0001);

    // R5 unknown format code
    agent_fmt[7:4] = 4'h5;
    run("R5 bad format", 6'b00_1_000, 8'h03, 2'd0, 4'b0001);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule